// File: doc/BRIEF.md
# Video Link Rate Calculator

This block works out the serial link clock, in kHz, that a display video mode needs on a multi-lane packet link. It takes the horizontal and vertical timing of the mode, a pixel format code, a transfer mode code, the lane count, an end-of-transmission packet enable and the refresh rate. From these it derives the bytes per line, with the fixed packet overheads added, then the bytes per frame and per second. It then spreads the load across the lanes and converts the result to a clock in kHz.

A second, simpler method is available through a mode input. In that mode the result is the pixel clock times the bits per pixel, divided by the lane count and rounded to the nearest integer. A single start pulse captures every input. The calculation then runs as a multi-cycle datapath: one wide multiply per state, and a shared bit-serial divider for each division. A one-cycle done pulse shows that the result and the error flag are valid. Both hold until the next done.

Top module: `link_rate_calc`

## Requirements
- R1: Bits per pixel follow the format code: 0 gives 24, 1 (packed 18-bit colour) gives 18, 2 (loosely packed 18-bit colour) gives 24, 3 gives 16, and any code from 4 to 7 gives 24.
- R2: The four horizontal segments are front porch = sync begin − active, sync width = sync end − sync begin, back porch = total − sync end, and active. Each segment costs ceil(pixels × bpp / 8) bytes.
- R3: A line costs the four segment byte counts plus a fixed 32 bytes of packet overhead.
- R4: The frame line count is the sum of the vertical sync, back porch, active and front porch segments. The timing result is floor(floor(line bytes × lines × refresh / lanes) × 8 / 1000).
- R5: The transfer mode code decides the end-of-transmission handling when the enable is set. Code 2 (burst) adds 4 bytes to every line and doubles the final result. Codes 0 and 1 (non-burst) add 4 bytes once per frame. Code 3 adds nothing. With the enable clear, all modes give the same result.
- R6: With the pixel-clock mode selected, the result is (pixel clock × bpp + floor(lanes / 2)) / lanes, truncated, which rounds to the nearest integer.
- R7: A start pulse in the idle state captures all inputs. Input changes after that, and start pulses during a calculation, have no effect on the result, and those pulses do not begin a new calculation.
- R8: Done is high for exactly one cycle per accepted start. The result and the error flag change only together with done and hold their values in between.
- R9: A lane count of 0 gives done with the error flag set and a result of 0, and no division is started. The next good calculation clears the error flag.
- R10: All intermediate values are 48 bits wide. A mode with a 65535-line frame, 60000-pixel active lines and refresh 255 gives the exact result, which is wider than 32 bits.
- R11: After reset, done, the error flag and the result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin a calculation |
| pix_mode | input | 1 | 1: pixel-clock method, 0: timing method |
| fmt | input | 3 | Pixel format code |
| xfer | input | 2 | Transfer mode code (0, 1 non-burst, 2 burst) |
| lanes | input | 3 | Number of data lanes |
| eot_en | input | 1 | End-of-transmission packet enable |
| refresh | input | 8 | Frames per second |
| pclk_khz | input | 24 | Pixel clock in kHz (pixel-clock method) |
| h_act | input | 16 | Horizontal active pixels |
| h_sync_beg | input | 16 | Horizontal sync begin |
| h_sync_end | input | 16 | Horizontal sync end |
| h_total | input | 16 | Horizontal total |
| v_act | input | 16 | Vertical active lines |
| v_sync_beg | input | 16 | Vertical sync begin |
| v_sync_end | input | 16 | Vertical sync end |
| v_total | input | 16 | Vertical total |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Lane count was zero |
| rate_khz | output | 48 | Link clock in kHz |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while a calculation is running and carries different inputs. To show that the block ignores it, the bench launches a known timing vector and changes every input a few cycles later. It then pulses start again and checks that the only done that follows still carries the first vector's value. Rounding also needs care. The format and segment widths are chosen so that the round-up for 18-bit pixels, the round-to-nearest of the pixel-clock path and the truncation by 1000 each change the final value by a unit. A large mode pushes the intermediate products past 32 bits.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PIX,
        PH_LINE,
        PH_FRAME,
        PH_RATE,
        PH_DIV1,
        PH_WAIT1,
        PH_DIV2,
        PH_WAIT2
    } phase_e;

    localparam logic [1:0] XF_PULSE  = 2'd0;
    localparam logic [1:0] XF_EVENTS = 2'd1;
    localparam logic [1:0] XF_BURST  = 2'd2;

    localparam logic [2:0] FMT_RGB888  = 3'd0;
    localparam logic [2:0] FMT_RGB666P = 3'd1;
    localparam logic [2:0] FMT_RGB666L = 3'd2;
    localparam logic [2:0] FMT_RGB565  = 3'd3;

    localparam int unsigned PKT_SYNC  = 4;
    localparam int unsigned PKT_XTRA  = 6;
    localparam int unsigned NUM_SEG   = 4;
    localparam int unsigned EOT_BYTES = 4;
    localparam int unsigned KHZ_DIV   = 1000;

    function automatic logic [4:0] bpp_of(input logic [2:0] code);
        case (code)
            FMT_RGB888, FMT_RGB666L: return 5'd24;
            FMT_RGB666P:             return 5'd18;
            FMT_RGB565:              return 5'd16;
            default:                 return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/lrc_iter_div.sv
module lrc_iter_div #(
    parameter int DW = 48,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [SW-1:0] den,
    output logic          fin,
    output logic [DW-1:0] quo
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic [DW-1:0] sh;
        logic [SW-1:0] rem;
        logic [SW-1:0] den;
        logic [CW-1:0] cnt;
        logic          run;
        logic          fin;
    } div_t;

    div_t q, d;
    logic [SW:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        trial = {q.rem, q.sh[DW-1]};
        if (go) begin
            d.sh  = num;
            d.rem = '0;
            d.den = den;
            d.cnt = CW'(DW);
            d.run = 1'b1;
        end else if (q.run) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = SW'(trial - {1'b0, q.den});
                d.sh  = {q.sh[DW-2:0], 1'b1};
            end else begin
                d.rem = trial[SW-1:0];
                d.sh  = {q.sh[DW-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
    assign quo = q.sh;

endmodule

// File: rtl/lrc_line_bytes.sv
module lrc_line_bytes
    import lrc_pkg::*;
#(
    parameter int TW = 16,
    parameter int AW = 48
) (
    input  logic [4:0]    bpp,
    input  logic [TW-1:0] act,
    input  logic [TW-1:0] sbeg,
    input  logic [TW-1:0] send,
    input  logic [TW-1:0] total,
    input  logic          eot_line,
    output logic [AW-1:0] bytes
);
    localparam logic [AW-1:0] OVH = AW'(2 * PKT_SYNC + NUM_SEG * PKT_XTRA);
    localparam logic [AW-1:0] RND = AW'(7);

    logic [TW-1:0] px    [NUM_SEG];
    logic [AW-1:0] seg_b [NUM_SEG];

    // front porch, sync width, back porch, active
    assign px[0] = sbeg - act;
    assign px[1] = send - sbeg;
    assign px[2] = total - send;
    assign px[3] = act;

    for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_seg
        assign seg_b[gi] = (AW'(px[gi]) * AW'(bpp) + RND) >> 3;
    end

    always_comb begin
        bytes = OVH + (eot_line ? AW'(EOT_BYTES) : '0);
        for (int i = 0; i < NUM_SEG; i++) begin
            bytes = bytes + seg_b[i];
        end
    end

endmodule

// File: rtl/link_rate_calc.sv
module link_rate_calc
    import lrc_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 24,
    parameter int RW = 8,
    parameter int LW = 3,
    parameter int AW = 48,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pix_mode,
    input  logic [2:0]    fmt,
    input  logic [1:0]    xfer,
    input  logic [LW-1:0] lanes,
    input  logic          eot_en,
    input  logic [RW-1:0] refresh,
    input  logic [PW-1:0] pclk_khz,
    input  logic [TW-1:0] h_act,
    input  logic [TW-1:0] h_sync_beg,
    input  logic [TW-1:0] h_sync_end,
    input  logic [TW-1:0] h_total,
    input  logic [TW-1:0] v_act,
    input  logic [TW-1:0] v_sync_beg,
    input  logic [TW-1:0] v_sync_end,
    input  logic [TW-1:0] v_total,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] rate_khz
);
    typedef struct packed {
        phase_e        ph;
        logic          pix;
        logic [2:0]    fmt;
        logic [1:0]    xf;
        logic [LW-1:0] ln;
        logic          eot;
        logic [RW-1:0] rate;
        logic [PW-1:0] pclk;
        logic [TW-1:0] ha;
        logic [TW-1:0] hs;
        logic [TW-1:0] he;
        logic [TW-1:0] ht;
        logic [TW-1:0] va;
        logic [TW-1:0] vs;
        logic [TW-1:0] ve;
        logic [TW-1:0] vt;
        logic [AW-1:0] acc;
        logic          done;
        logic          err;
        logic [AW-1:0] res;
    } ctx_t;

    ctx_t q, d;

    logic [4:0]    bpp;
    logic [AW-1:0] line_b;
    logic [TW-1:0] vlines;
    logic          burst_eot;
    logic          frame_eot;
    logic          div_go;
    logic [SW-1:0] div_den;
    logic          div_fin;
    logic [AW-1:0] div_quo;

    assign bpp       = bpp_of(q.fmt);
    assign burst_eot = q.eot && (q.xf == XF_BURST);
    assign frame_eot = q.eot && ((q.xf == XF_PULSE) || (q.xf == XF_EVENTS));
    assign vlines    = (q.vs - q.va) + (q.ve - q.vs) + (q.vt - q.ve) + q.va;
    assign div_go    = (q.ph == PH_DIV1) || (q.ph == PH_DIV2);
    assign div_den   = (q.ph == PH_DIV2) ? SW'(KHZ_DIV) : SW'(q.ln);

    lrc_line_bytes #(
        .TW(TW),
        .AW(AW)
    ) u_line (
        .bpp     (bpp),
        .act     (q.ha),
        .sbeg    (q.hs),
        .send    (q.he),
        .total   (q.ht),
        .eot_line(burst_eot),
        .bytes   (line_b)
    );

    lrc_iter_div #(
        .DW(AW),
        .SW(SW)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (q.acc),
        .den  (div_den),
        .fin  (div_fin),
        .quo  (div_quo)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.pix  = pix_mode;
                    d.fmt  = fmt;
                    d.xf   = xfer;
                    d.ln   = lanes;
                    d.eot  = eot_en;
                    d.rate = refresh;
                    d.pclk = pclk_khz;
                    d.ha   = h_act;
                    d.hs   = h_sync_beg;
                    d.he   = h_sync_end;
                    d.ht   = h_total;
                    d.va   = v_act;
                    d.vs   = v_sync_beg;
                    d.ve   = v_sync_end;
                    d.vt   = v_total;
                    if (lanes == '0) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                        d.res  = '0;
                    end else begin
                        d.ph = pix_mode ? PH_PIX : PH_LINE;
                    end
                end
            end
            PH_PIX: begin
                d.acc = AW'(q.pclk) * AW'(bpp) + AW'(q.ln >> 1);
                d.ph  = PH_DIV1;
            end
            PH_LINE: begin
                d.acc = line_b;
                d.ph  = PH_FRAME;
            end
            PH_FRAME: begin
                d.acc = q.acc * AW'(vlines) + (frame_eot ? AW'(EOT_BYTES) : '0);
                d.ph  = PH_RATE;
            end
            PH_RATE: begin
                d.acc = q.acc * AW'(q.rate);
                d.ph  = PH_DIV1;
            end
            PH_DIV1: d.ph = PH_WAIT1;
            PH_WAIT1: begin
                if (div_fin) begin
                    if (q.pix) begin
                        d.res  = div_quo;
                        d.err  = 1'b0;
                        d.done = 1'b1;
                        d.ph   = PH_IDLE;
                    end else begin
                        d.acc = div_quo << 3;
                        d.ph  = PH_DIV2;
                    end
                end
            end
            PH_DIV2: d.ph = PH_WAIT2;
            PH_WAIT2: begin
                if (div_fin) begin
                    d.res  = burst_eot ? (div_quo << 1) : div_quo;
                    d.err  = 1'b0;
                    d.done = 1'b1;
                    d.ph   = PH_IDLE;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done     = q.done;
    assign err      = q.err;
    assign rate_khz = q.res;

endmodule

// File: rtl/lrc_chk.sv
module lrc_chk #(
    parameter int AW = 48,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] rate_khz,
    input logic          div_go,
    input logic [SW-1:0] div_den
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rate_khz) && $stable(err)));

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rate_khz == '0));

    // R9
    no_zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> (div_den != '0));
endmodule

bind link_rate_calc lrc_chk #(
    .AW(AW),
    .SW(SW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .err     (err),
    .rate_khz(rate_khz),
    .div_go  (div_go),
    .div_den (div_den)
);

// File: tb/link_rate_calc_test.sv
`timescale 1ns/1ps
module link_rate_calc_test;

    typedef struct packed {
        logic        pix;
        logic [2:0]  fmt;
        logic [1:0]  xf;
        logic [2:0]  ln;
        logic        eot;
        logic [7:0]  rate;
        logic [23:0] pclk;
        logic [15:0] ha, hs, he, ht, va, vs, ve, vt;
        logic [47:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        // R2 R3 R4: base timing vector
        '{1'b0, 3'd0, 2'd0, 3'd2, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd153, 4'd4},
        // R5: non-burst pulse, per-frame add
        '{1'b0, 3'd0, 2'd0, 3'd2, 1'b1, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd154, 4'd5},
        // R5: non-burst events, per-frame add
        '{1'b0, 3'd0, 2'd1, 3'd2, 1'b1, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd154, 4'd5},
        // R5: burst, per-line add and doubling
        '{1'b0, 3'd0, 2'd2, 3'd2, 1'b1, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd322, 4'd5},
        // R5: burst without enable
        '{1'b0, 3'd0, 2'd2, 3'd2, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd153, 4'd5},
        // R5: code 3 adds nothing
        '{1'b0, 3'd0, 2'd3, 3'd2, 1'b1, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd153, 4'd5},
        // R1 R2: packed 18-bit, round up
        '{1'b0, 3'd1, 2'd0, 3'd2, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd132, 4'd1},
        // R1: loose 18-bit
        '{1'b0, 3'd2, 2'd0, 3'd2, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd153, 4'd1},
        // R1: 16-bit
        '{1'b0, 3'd3, 2'd0, 3'd2, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd122, 4'd1},
        // R1: unknown code
        '{1'b0, 3'd5, 2'd0, 3'd2, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd153, 4'd1},
        // R4: three lanes, truncation
        '{1'b0, 3'd0, 2'd0, 3'd3, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd102, 4'd4},
        // R4: one lane
        '{1'b0, 3'd0, 2'd0, 3'd1, 1'b0, 8'd60, 24'd0, 16'd8, 16'd10, 16'd12, 16'd16, 16'd4, 16'd5, 16'd6, 16'd8, 48'd307, 4'd4},
        // R4: full HD style mode
        '{1'b0, 3'd0, 2'd0, 3'd4, 1'b0, 8'd60, 24'd0, 16'd1920, 16'd2008, 16'd2052, 16'd2200, 16'd1080, 16'd1084, 16'd1089, 16'd1125, 48'd895320, 4'd4},
        // R10: wide result
        '{1'b0, 3'd0, 2'd0, 3'd1, 1'b0, 8'd255, 24'd0, 16'd60000, 16'd60000, 16'd60000, 16'd60000, 16'd65535, 16'd65535, 16'd65535, 16'd65535, 48'd24068730124, 4'd10},
        // R6: pixel-clock path
        '{1'b1, 3'd0, 2'd0, 3'd4, 1'b0, 8'd0, 24'd148500, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 48'd891000, 4'd6},
        '{1'b1, 3'd0, 2'd0, 3'd3, 1'b0, 8'd0, 24'd148500, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 48'd1188000, 4'd6},
        '{1'b1, 3'd3, 2'd0, 3'd3, 1'b0, 8'd0, 24'd148500, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 48'd792000, 4'd6},
        // R6: 31.5 rounds to 32
        '{1'b1, 3'd1, 2'd0, 3'd4, 1'b0, 8'd0, 24'd7, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 48'd32, 4'd6},
        // R6: 22.5 rounds to 23
        '{1'b1, 3'd1, 2'd0, 3'd4, 1'b0, 8'd0, 24'd5, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 48'd23, 4'd6},
        // R6: 5.33 rounds to 5
        '{1'b1, 3'd3, 2'd0, 3'd3, 1'b0, 8'd0, 24'd1, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 48'd5, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pix_mode = 1'b0;
    logic [2:0]  fmt = '0;
    logic [1:0]  xfer = '0;
    logic [2:0]  lanes = '0;
    logic        eot_en = 1'b0;
    logic [7:0]  refresh = '0;
    logic [23:0] pclk_khz = '0;
    logic [15:0] h_act = '0, h_sync_beg = '0, h_sync_end = '0, h_total = '0;
    logic [15:0] v_act = '0, v_sync_beg = '0, v_sync_end = '0, v_total = '0;
    logic        done;
    logic        err;
    logic [47:0] rate_khz;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    link_rate_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_mode(pix_mode),
        .fmt(fmt), .xfer(xfer), .lanes(lanes), .eot_en(eot_en),
        .refresh(refresh), .pclk_khz(pclk_khz),
        .h_act(h_act), .h_sync_beg(h_sync_beg), .h_sync_end(h_sync_end), .h_total(h_total),
        .v_act(v_act), .v_sync_beg(v_sync_beg), .v_sync_end(v_sync_end), .v_total(v_total),
        .done(done), .err(err), .rate_khz(rate_khz)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        pix_mode = v.pix; fmt = v.fmt; xfer = v.xf; lanes = v.ln; eot_en = v.eot;
        refresh = v.rate; pclk_khz = v.pclk;
        h_act = v.ha; h_sync_beg = v.hs; h_sync_end = v.he; h_total = v.ht;
        v_act = v.va; v_sync_beg = v.vs; v_sync_end = v.ve; v_total = v.vt;
    endtask

    task automatic pulse_start;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v, input string req);
        bit got;
        apply(v);
        pulse_start();
        wait_done(got);
        chk(got, {req, " done seen"}, longint'(got), 1);
        chk(rate_khz == v.exp, req, longint'(rate_khz), longint'(v.exp));
        chk(err == 1'b0, {req, " err"}, longint'(err), 0);
        @(negedge clk);
        // R8: done lasts one cycle
        chk(done == 1'b0, "R8 done width", longint'(done), 0);
    endtask

    initial begin
        #600000;
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        bit got;
        int ndone;
        repeat (5) @(negedge clk);
        // R11: reset state
        chk(done == 1'b0, "R11 done", longint'(done), 0);
        chk(err == 1'b0, "R11 err", longint'(err), 0);
        chk(rate_khz == '0, "R11 result", longint'(rate_khz), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_vec(VT[k], $sformatf("R%0d vec%0d", VT[k].rq, k));
        end

        // R9: zero lanes
        apply(VT[0]);
        lanes = 3'd0;
        pulse_start();
        wait_done(got);
        chk(got, "R9 done seen", longint'(got), 1);
        chk(err == 1'b1, "R9 err set", longint'(err), 1);
        chk(rate_khz == '0, "R9 result zero", longint'(rate_khz), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done width after error", longint'(done), 0);
        // R9: a good run clears the error flag
        run_vec(VT[0], "R9 recover");

        // R7: inputs changed and start pulsed during a run
        apply(VT[0]);
        pulse_start();
        repeat (5) @(negedge clk);
        apply(VT[12]);
        pulse_start();
        wait_done(got);
        chk(got, "R7 done seen", longint'(got), 1);
        chk(rate_khz == VT[0].exp, "R7 captured inputs", longint'(rate_khz), longint'(VT[0].exp));
        @(negedge clk);
        ndone = 0;
        for (int i = 0; i < 300; i++) begin
            if (done) ndone++;
            @(negedge clk);
        end
        chk(ndone == 0, "R7 no extra run", longint'(ndone), 0);
        // R8: result holds between done pulses
        chk(rate_khz == VT[0].exp, "R8 result held", longint'(rate_khz), longint'(VT[0].exp));
        chk(err == 1'b0, "R8 err held", longint'(err), 0);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule